// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block issues refresh requests at a steady rate so that every row of a 512-row refresh space is visited within the retention window. A free-running interval timer adds one pending refresh per slot. The slot length is a parameter in clock cycles, about 15.6 µs of wall time for an 8 ms window. A period select input stretches it to the 64 ms window used by low-power parts. Pending refreshes accumulate as debt up to a parameterised ceiling. When the debt reaches that ceiling the block raises an urgency flag, so the access sequencer can stop deferring refresh.

Refreshes go to the access sequencer through a request/grant/done handshake. A style select input chooses how each refresh is performed, and the style is latched at grant. In row-address style the block drives a row address from its own counter. That counter steps once per completed refresh and wraps back to zero after the last row. In internal-counter style the device's own counter picks the row, so no address is driven. The hidden style is a variant of internal-counter style: the sequencer keeps CAS low after a read, so the read data stays valid while RAS cycles. The strobe waveforms are produced by the sequencer, not by this block.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ref_req`, `row_addr_en` and `urgent` are 0, and `debt` and `row_addr` are 0.
- R2: With `long_period` = 0, one refresh becomes pending every `STD_CYC` clock cycles. The first `ref_req` appears after exactly `STD_CYC` rising edges following reset release.
- R3: With `long_period` = 1, the pending interval is `LP_CYC` clock cycles. The first `ref_req` appears after exactly `LP_CYC` rising edges following reset release.
- R4: `ref_req` is high whenever `debt` is non-zero and no refresh is in progress. A `ref_grant` seen while `ref_req` is high starts a refresh, and `ref_req` is low from the next cycle until the matching `ref_done`. That `ref_done` lowers `debt` by one.
- R5: Mode code 2'b00 selects row-address style. While such a refresh is requested or in progress, `ref_style` reads 2'b00, `row_addr_en` is 1 and `row_addr` carries the row counter.
- R6: A completed row-address refresh advances the row counter by one. The counter wraps from `ROWS`-1 to 0.
- R7: Mode codes 2'b01 and 2'b11 select internal-counter style. `ref_style` reads 2'b01, `row_addr_en` stays 0, and completing the refresh leaves `row_addr` unchanged.
- R8: Mode code 2'b10 selects hidden style. `ref_style` reads 2'b10, `row_addr_en` stays 0, and `row_addr` is unchanged by the refresh.
- R9: The style is captured at grant and holds until `ref_done`, even if `mode_sel` changes meanwhile.
- R10: `debt` rises by one per interval and saturates at `DEBT_LIMIT`. `urgent` is 1 exactly while `debt` equals `DEBT_LIMIT`.
- R11: A `ref_done` with no refresh in progress changes neither `debt` nor `row_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Refresh style code: 00 row-address, 01/11 internal counter, 10 hidden |
| long_period | input | 1 | 0: 8 ms spacing (`STD_CYC`), 1: 64 ms spacing (`LP_CYC`) |
| ref_grant | input | 1 | Sequencer accepts the pending refresh |
| ref_done | input | 1 | Sequencer finished the refresh in progress |
| ref_req | output | 1 | A refresh is pending and none is in progress |
| ref_style | output | 2 | Style of the requested or in-progress refresh |
| row_addr | output | ROW_W | Row to refresh in row-address style |
| row_addr_en | output | 1 | `row_addr` is meaningful for the current refresh |
| debt | output | DEBT_W | Count of refreshes pending |
| urgent | output | 1 | Debt has reached `DEBT_LIMIT` |

## Verification
On every cycle, the bound checker tests several properties. It checks that the request drops after a grant, and that the debt stays within its ceiling and moves by at most one step. It checks that urgency only rises from one step below the ceiling, that the row address moves only after a done and wraps to zero, that the address enable is seen only with row-address style, and that the style stays fixed during a refresh. The exact interval lengths for both period settings, the full 512-row sweep with its wrap, debt saturation and draining, and the fact that a stray done is ignored depend on timed stimulus, so only the bench scenarios show them.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

   typedef enum logic [1:0] {
      RF_ROWADDR  = 2'b00,
      RF_INTCOUNT = 2'b01,
      RF_HIDDEN   = 2'b10
   } rf_style_e;

   function automatic rf_style_e rf_decode(input logic [1:0] code);
      case (code)
         2'b00:   rf_decode = RF_ROWADDR;
         2'b10:   rf_decode = RF_HIDDEN;
         default: rf_decode = RF_INTCOUNT;
      endcase
   endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
   parameter int STD_CYC = 1562,
   parameter int LP_CYC  = 12500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic long_period,
   output logic tick
);
   localparam int MAXC = (LP_CYC > STD_CYC) ? LP_CYC : STD_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;

   generate
      if (STD_CYC == LP_CYC) begin : g_single
         assign lim = CW'(STD_CYC);
      end else begin : g_dual
         assign lim = long_period ? CW'(LP_CYC) : CW'(STD_CYC);
      end
   endgenerate

   // >= covers a switch to the shorter period mid-count
   assign tick = (cnt_q >= lim - CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/rfsh_debt_ctr.sv
module rfsh_debt_ctr #(
   parameter int DEBT_LIMIT = 8,
   localparam int DEBT_W    = $clog2(DEBT_LIMIT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              dec,
   output logic [DEBT_W-1:0] count,
   output logic              at_limit
);
   localparam logic [DEBT_W-1:0] LIM = DEBT_W'(DEBT_LIMIT);

   logic [DEBT_W-1:0] cnt_q;

   assign count    = cnt_q;
   assign at_limit = (cnt_q == LIM);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else if (inc && !dec && !at_limit) cnt_q <= cnt_q + DEBT_W'(1);
      else if (dec && !inc && cnt_q != '0) cnt_q <= cnt_q - DEBT_W'(1);
   end
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
   parameter int ROWS  = 512,
   localparam int ROW_W = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [ROW_W-1:0] row
);
   logic [ROW_W-1:0] row_q;
   logic [ROW_W-1:0] row_nx;

   generate
      if ((1 << ROW_W) == ROWS) begin : g_pow2
         assign row_nx = row_q + ROW_W'(1);
      end else begin : g_cmp
         assign row_nx = (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + ROW_W'(1);
      end
   endgenerate

   assign row = row_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   row_q <= '0;
      else if (adv) row_q <= row_nx;
   end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
   import dram_rfsh_pkg::*;
#(
   parameter int ROWS       = 512,
   parameter int STD_CYC    = 1562,
   parameter int LP_CYC     = 12500,
   parameter int DEBT_LIMIT = 8,
   localparam int ROW_W     = $clog2(ROWS),
   localparam int DEBT_W    = $clog2(DEBT_LIMIT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_sel,
   input  logic              long_period,
   input  logic              ref_grant,
   input  logic              ref_done,
   output logic              ref_req,
   output logic [1:0]        ref_style,
   output logic [ROW_W-1:0]  row_addr,
   output logic              row_addr_en,
   output logic [DEBT_W-1:0] debt,
   output logic              urgent
);
   generate
      if (ROWS < 2)              begin : g_bad_rows  $error("ROWS must be at least 2"); end
      if (STD_CYC < 2)           begin : g_bad_std   $error("STD_CYC must be at least 2"); end
      if (LP_CYC < STD_CYC)      begin : g_bad_lp    $error("LP_CYC must not be below STD_CYC"); end
      if (DEBT_LIMIT < 1)        begin : g_bad_debt  $error("DEBT_LIMIT must be at least 1"); end
   endgenerate

   logic      tick;
   logic      busy_q;
   rf_style_e style_q;
   rf_style_e style_eff;
   logic      grant_ok;
   logic      done_ok;

   assign grant_ok  = ref_grant && ref_req;
   assign done_ok   = ref_done && busy_q;
   assign style_eff = busy_q ? style_q : rf_decode(mode_sel);

   rfsh_interval_timer #(.STD_CYC(STD_CYC), .LP_CYC(LP_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .long_period(long_period), .tick(tick)
   );

   rfsh_debt_ctr #(.DEBT_LIMIT(DEBT_LIMIT)) u_debt (
      .clk(clk), .rst_n(rst_n), .inc(tick), .dec(done_ok),
      .count(debt), .at_limit(urgent)
   );

   rfsh_row_ctr #(.ROWS(ROWS)) u_row (
      .clk(clk), .rst_n(rst_n),
      .adv(done_ok && style_q == RF_ROWADDR),
      .row(row_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         style_q <= RF_ROWADDR;
      end else if (grant_ok) begin
         busy_q  <= 1'b1;
         style_q <= rf_decode(mode_sel);
      end else if (done_ok) begin
         busy_q  <= 1'b0;
      end
   end

   assign ref_req     = (debt != '0) && !busy_q;
   assign ref_style   = style_eff;
   assign row_addr_en = (ref_req || busy_q) && (style_eff == RF_ROWADDR);
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
   parameter int ROWS       = 512,
   parameter int DEBT_LIMIT = 8,
   localparam int ROW_W     = $clog2(ROWS),
   localparam int DEBT_W    = $clog2(DEBT_LIMIT + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_req,
   input logic              ref_grant,
   input logic              ref_done,
   input logic [1:0]        ref_style,
   input logic [ROW_W-1:0]  row_addr,
   input logic              row_addr_en,
   input logic [DEBT_W-1:0] debt,
   input logic              urgent,
   input logic              busy
);
   assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && ref_grant) |=> !ref_req);

   assert_debt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      debt <= DEBT_W'(DEBT_LIMIT));

   assert_debt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (DEBT_W'(debt) <= DEBT_W'($past(debt) + DEBT_W'(1))) &&
      (DEBT_W'($past(debt)) <= DEBT_W'(debt + DEBT_W'(1))) || debt == '0 || $past(debt) == '0);

   assert_urgent_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(urgent) |-> ($past(debt) == DEBT_W'(DEBT_LIMIT - 1) || $past(debt) == DEBT_W'(DEBT_LIMIT)));

   assert_row_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ref_done) |-> $stable(row_addr));

   assert_row_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(row_addr) == ROW_W'(ROWS - 1) && !$stable(row_addr)) |-> row_addr == '0);

   assert_addr_style_R5: assert property (@(posedge clk) disable iff (!rst_n)
      row_addr_en |-> ref_style == 2'b00);

   assert_style_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy) |-> $stable(ref_style));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.ROWS(ROWS), .DEBT_LIMIT(DEBT_LIMIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_grant(ref_grant),
   .ref_done(ref_done), .ref_style(ref_style), .row_addr(row_addr),
   .row_addr_en(row_addr_en), .debt(debt), .urgent(urgent), .busy(busy_q)
);

// File: tb/dram_refresh_sched_test.sv
`timescale 1ns/1ps
module dram_refresh_sched_test;
   localparam int ROWS   = 512;
   localparam int STD    = 16;
   localparam int LP     = 48;
   localparam int DLIM   = 4;
   localparam int ROW_W  = $clog2(ROWS);
   localparam int DEBT_W = $clog2(DLIM + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic long_period = 1'b0;
   logic ref_grant = 1'b0;
   logic ref_done = 1'b0;
   logic ref_req;
   logic [1:0] ref_style;
   logic [ROW_W-1:0] row_addr;
   logic row_addr_en;
   logic [DEBT_W-1:0] debt;
   logic urgent;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   dram_refresh_sched #(.ROWS(ROWS), .STD_CYC(STD), .LP_CYC(LP), .DEBT_LIMIT(DLIM)) uut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .long_period(long_period),
      .ref_grant(ref_grant), .ref_done(ref_done), .ref_req(ref_req),
      .ref_style(ref_style), .row_addr(row_addr), .row_addr_en(row_addr_en),
      .debt(debt), .urgent(urgent)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic lp);
      rst_n = 1'b0;
      long_period = lp;
      ref_grant = 1'b0;
      ref_done = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic serve(input logic [1:0] m, output int row_seen, output int en_seen,
                        output int sty_seen, output int req_seen);
      while (!ref_req) @(negedge clk);
      mode_sel = m;
      ref_grant = 1'b1;
      @(negedge clk);
      ref_grant = 1'b0;
      row_seen = int'(row_addr);
      en_seen  = int'(row_addr_en);
      sty_seen = int'(ref_style);
      req_seen = int'(ref_req);
      ref_done = 1'b1;
      @(negedge clk);
      ref_done = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int r, e, s, q, cnt, row0;

      // R1 reset state, visible during reset and right after release
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1 req", ref_req, 0);
      check("R1 debt", debt, 0);
      check("R1 urgent", urgent, 0);
      check("R1 row", row_addr, 0);
      check("R1 addr_en", row_addr_en, 0);

      // R2 first request after STD edges
      do_reset(1'b0);
      cnt = 0;
      while (cnt < 10 * LP) begin
         @(posedge clk); cnt++;
         @(negedge clk);
         if (ref_req) break;
      end
      check("R2 interval", cnt, STD);

      // R3 long period
      do_reset(1'b1);
      cnt = 0;
      while (cnt < 10 * LP) begin
         @(posedge clk); cnt++;
         @(negedge clk);
         if (ref_req) break;
      end
      check("R3 interval", cnt, LP);

      // R11 stray done right after reset
      do_reset(1'b0);
      ref_done = 1'b1;
      @(negedge clk);
      ref_done = 1'b0;
      check("R11 debt", debt, 0);
      check("R11 row", row_addr, 0);

      // R5/R6 full row sweep with wrap, R4 handshake
      for (int i = 0; i <= ROWS; i++) begin
         serve(2'b00, r, e, s, q);
         check("R6 row", r, i % ROWS);
         check("R5 addr_en", e, 1);
         check("R5 style", s, 0);
         check("R4 req low in refresh", q, 0);
      end
      check("R6 row after wrap", row_addr, 1);
      check("R4 debt drained", debt, 0);

      // R7 internal counter styles
      row0 = int'(row_addr);
      serve(2'b01, r, e, s, q);
      check("R7 style 01", s, 1);
      check("R7 addr_en", e, 0);
      check("R7 row kept", row_addr, row0);
      serve(2'b11, r, e, s, q);
      check("R7 style 11", s, 1);
      check("R7 addr_en 11", e, 0);
      check("R7 row kept 11", row_addr, row0);

      // R8 hidden style
      serve(2'b10, r, e, s, q);
      check("R8 style", s, 2);
      check("R8 addr_en", e, 0);
      check("R8 row kept", row_addr, row0);

      // R9 style latched while in progress
      while (!ref_req) @(negedge clk);
      mode_sel = 2'b00;
      ref_grant = 1'b1;
      @(negedge clk);
      ref_grant = 1'b0;
      mode_sel = 2'b10;
      @(negedge clk);
      check("R9 style held", ref_style, 0);
      check("R9 addr_en held", row_addr_en, 1);
      ref_done = 1'b1;
      @(negedge clk);
      ref_done = 1'b0;
      check("R9 row advanced", row_addr, (row0 + 1) % ROWS);
      check("R9 style follows mode after done", ref_style, 2);
      mode_sel = 2'b00;

      // R10 debt accumulation and saturation
      do_reset(1'b0);
      for (int k = 1; k <= DLIM + 2; k++) begin
         repeat (STD) @(posedge clk);
         @(negedge clk);
         check("R10 debt", debt, (k < DLIM) ? k : DLIM);
         check("R10 urgent", urgent, (k >= DLIM) ? 1 : 0);
      end
      for (int j = 1; j <= DLIM; j++) begin
         serve(2'b01, r, e, s, q);
         check("R4 debt decrement", debt, DLIM - j);
         check("R10 urgent clear", urgent, 0);
      end
      check("R4 req idle", ref_req, 0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule